// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timing Generator

This block sequences the three timed phases of a single programmed-I/O access on an IDE channel pair. When a request arrives, the block holds the address-valid phase for the setup time. It then pulls the read strobe or the write strobe low for the active time, and keeps both strobes high for the recovery time. One clock after recovery ends it pulses done. Every duration is a whole number of system clocks.

Each of the four attached drives has its own setup, active and recovery settings: the primary channel's drive 0 and drive 1, and the secondary channel's drive 0 and drive 1. These settings are held in two configuration registers, which are loaded through a one-cycle write port. The request carries a 2-bit drive index and a read/write flag. The selected drive's settings are captured at the moment the request is accepted. A register write made while an access is running therefore only affects later accesses.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, the timing word is A8A8A8A8h and the setup byte is FFh. Every drive then gets 4 setup clocks, 11 active clocks and 9 recovery clocks. Both strobes are high, and busy and done are low.
- R2: Drive index d (0 = primary drive 0, 1 = primary drive 1, 2 = secondary drive 0, 3 = secondary drive 1) takes its 2-bit setup code from setup byte bits [7-2d : 6-2d]. The code gives code+1 setup clocks (00 gives 1, 11 gives 4).
- R3: Drive d takes its 4-bit active code from timing word bits [31-8d : 28-8d]. The strobe stays low for exactly code+1 clocks.
- R4: Drive d takes its 4-bit recovery code from timing word bits [27-8d : 24-8d]. Both strobes stay high and busy stays high for exactly code+1 clocks after the active phase.
- R5: A request with the read flag at 1 drives only the read strobe low, and with the flag at 0 only the write strobe. The two strobes are never low together, and both are high outside the active phase.
- R6: Busy is high from the clock after acceptance until recovery ends. Done is high for exactly the one clock after busy falls, and low at all other times.
- R7: A request that arrives while busy is high is ignored. It starts no further access.
- R8: A register write made during an access leaves that access's timing unchanged. The next access uses the new values.
- R9: Every access goes through setup, then active, then recovery, then idle, in that order. No phase is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle register write enable |
| cfg_sel | input | 1 | Write target: 0 selects the timing word, 1 selects the setup byte (cfg_wdata[7:0]) |
| cfg_wdata | input | 32 | Register write data |
| req | input | 1 | Access request, accepted only while idle |
| req_drive | input | 2 | Drive index of the request |
| req_read | input | 1 | 1 for a read access, 0 for a write access |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock pulse after recovery ends |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
A wrong phase counter or a wrong captured field shows up within one access: the setup, active or recovery length of that drive deviates by at least one clock at the strobe and busy pins. A bad field decode shows up as a length that belongs to a different drive's nibble. The bench therefore sweeps all four drive indices over many register patterns and compares every phase length with the arithmetic value. A wrong capture moment shows up only on the access that overlaps a register write, so the bench writes new values in the middle of accesses and checks both that access and the one after it.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;
endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs #(
    parameter int DRIVES = 4,
    parameter int CNT_W  = 4,
    parameter int SET_W  = 2,
    parameter logic [CNT_W-1:0] PULSE_RST = 4'b1010,
    parameter logic [CNT_W-1:0] RECOV_RST = 4'b1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr,
    input  logic                        cfg_sel,
    input  logic [DRIVES*2*CNT_W-1:0]   cfg_wdata,
    input  logic [$clog2(DRIVES)-1:0]   drive_sel,
    output logic [SET_W-1:0]            sel_setup,
    output logic [CNT_W-1:0]            sel_pulse,
    output logic [CNT_W-1:0]            sel_recov
);
    localparam int WORD_W = DRIVES * 2 * CNT_W;
    localparam int SREG_W = DRIVES * SET_W;
    localparam logic [WORD_W-1:0] WORD_RST = {DRIVES{PULSE_RST, RECOV_RST}};
    localparam logic [SREG_W-1:0] SREG_RST = {SREG_W{1'b1}};

    typedef struct packed {
        logic [WORD_W-1:0] timing;
        logic [SREG_W-1:0] setup;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr) begin
            if (cfg_sel)
                regs_d.setup = cfg_wdata[SREG_W-1:0];
            else
                regs_d.timing = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.timing <= WORD_RST;
            regs_q.setup  <= SREG_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Per-drive field slicing: drive 0 occupies the most significant fields.
    logic [CNT_W-1:0] pulse_f [DRIVES];
    logic [CNT_W-1:0] recov_f [DRIVES];
    logic [SET_W-1:0] setup_f [DRIVES];

    for (genvar d = 0; d < DRIVES; d++) begin : g_drive
        localparam int PHI = WORD_W - 1 - 2 * CNT_W * d;
        localparam int RHI = PHI - CNT_W;
        localparam int SHI = SREG_W - 1 - SET_W * d;
        assign pulse_f[d] = regs_q.timing[PHI -: CNT_W];
        assign recov_f[d] = regs_q.timing[RHI -: CNT_W];
        assign setup_f[d] = regs_q.setup[SHI -: SET_W];
    end

    assign sel_pulse = pulse_f[drive_sel];
    assign sel_recov = recov_f[drive_sel];
    assign sel_setup = setup_f[drive_sel];

    // R8: a write only changes the targeted register
    assert_write_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel) |=> $stable(regs_q.timing));
endmodule

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
    import pio_timing_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int SET_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_read,
    input  logic [SET_W-1:0] ld_setup,
    input  logic [CNT_W-1:0] ld_pulse,
    input  logic [CNT_W-1:0] ld_recov,
    output logic             busy,
    output logic             done,
    output logic             rd_n,
    output logic             wr_n
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pulse;
        logic [CNT_W-1:0] recov;
        logic             is_read;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic cnt_zero;

    assign cnt_zero = (ctl_q.cnt == '0);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (req) begin
                    ctl_d.phase   = PH_SETUP;
                    ctl_d.cnt     = CNT_W'(ld_setup);
                    ctl_d.pulse   = ld_pulse;
                    ctl_d.recov   = ld_recov;
                    ctl_d.is_read = req_read;
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    ctl_d.phase = PH_ACTIVE;
                    ctl_d.cnt   = ctl_q.pulse;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            PH_ACTIVE: begin
                if (cnt_zero) begin
                    ctl_d.phase = PH_RECOV;
                    ctl_d.cnt   = ctl_q.recov;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            PH_RECOV: begin
                if (cnt_zero) begin
                    ctl_d.phase = PH_IDLE;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, cnt: '0, pulse: '0, recov: '0,
                       is_read: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = (ctl_q.phase != PH_IDLE);
    assign done = ctl_q.done;
    assign rd_n = !((ctl_q.phase == PH_ACTIVE) && ctl_q.is_read);
    assign wr_n = !((ctl_q.phase == PH_ACTIVE) && !ctl_q.is_read);

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_done_follows_recov_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_RECOV && cnt_zero) |=> (done && !busy));

    assert_done_only_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_ignores_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> ($stable(ctl_q.is_read) && $stable(ctl_q.pulse)));

    assert_active_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_ACTIVE && !cnt_zero) |=> (ctl_q.phase == PH_ACTIVE));

    assert_phase_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_ACTIVE) |-> ($past(ctl_q.phase) == PH_SETUP ||
                                         $past(ctl_q.phase) == PH_ACTIVE));

    assert_recov_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_RECOV) |-> ($past(ctl_q.phase) == PH_ACTIVE ||
                                        $past(ctl_q.phase) == PH_RECOV));
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer #(
    parameter int DRIVES = 4,
    parameter int CNT_W  = 4,
    parameter int SET_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr,
    input  logic                        cfg_sel,
    input  logic [DRIVES*2*CNT_W-1:0]   cfg_wdata,
    input  logic                        req,
    input  logic [$clog2(DRIVES)-1:0]   req_drive,
    input  logic                        req_read,
    output logic                        busy,
    output logic                        done,
    output logic                        rd_n,
    output logic                        wr_n
);
    logic [SET_W-1:0] sel_setup;
    logic [CNT_W-1:0] sel_pulse;
    logic [CNT_W-1:0] sel_recov;

    pio_cfg_regs #(
        .DRIVES (DRIVES),
        .CNT_W  (CNT_W),
        .SET_W  (SET_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .drive_sel (req_drive),
        .sel_setup (sel_setup),
        .sel_pulse (sel_pulse),
        .sel_recov (sel_recov)
    );

    pio_phase_ctrl #(
        .CNT_W (CNT_W),
        .SET_W (SET_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_read (req_read),
        .ld_setup (sel_setup),
        .ld_pulse (sel_pulse),
        .ld_recov (sel_recov),
        .busy     (busy),
        .done     (done),
        .rd_n     (rd_n),
        .wr_n     (wr_n)
    );

    // R1: strobes idle high whenever nothing is in progress
    assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n));
endmodule

// File: tb/pio_strobe_timer_tb.sv
module pio_strobe_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic [1:0]  req_drive = '0;
    logic        req_read = 1'b0;
    logic        busy, done, rd_n, wr_n;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] tim_m = 32'hA8A8A8A8;
    logic [7:0]  set_m = 8'hFF;

    always #5 clk = ~clk;

    pio_strobe_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req(req), .req_drive(req_drive),
        .req_read(req_read), .busy(busy), .done(done), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_setup(input logic [7:0] s, input int d);
        return int'(s[7-2*d -: 2]) + 1;
    endfunction
    function automatic int exp_pulse(input logic [31:0] t, input int d);
        return int'(t[31-8*d -: 4]) + 1;
    endfunction
    function automatic int exp_recov(input logic [31:0] t, input int d);
        return int'(t[27-8*d -: 4]) + 1;
    endfunction

    task automatic cfg_write(input bit sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel) set_m = data[7:0]; else tim_m = data;
    endtask

    // Runs one access; optionally writes registers mid-access and pokes req while busy.
    task automatic run_access(input int d, input bit rd, input bit mid_wr,
                              input logic [31:0] mid_tim, input bit poke);
        int s = 0, p = 0, r = 0, wrong = 0, done_early = 0, it = 0;
        int es, ep, er;
        bit seen_strobe = 0, finished = 0;
        es = exp_setup(set_m, d); ep = exp_pulse(tim_m, d); er = exp_recov(tim_m, d);
        @(negedge clk);
        req = 1'b1; req_drive = 2'(d); req_read = rd;
        @(negedge clk);
        req = 1'b0;
        while (!finished && it < 200) begin
            if (it == 0 && poke) req = 1'b1;
            if (it == 1) req = 1'b0;
            if (it == 0 && mid_wr) begin cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = mid_tim; end
            if (it == 1) cfg_wr = 1'b0;
            if (busy) begin
                if (done) done_early++;
                if (rd ? !wr_n : !rd_n) wrong++;
                if (!rd_n || !wr_n) begin
                    seen_strobe = 1; p++;
                end else if (!seen_strobe) s++;
                else r++;
                @(negedge clk);
                it++;
            end else begin
                finished = 1;
            end
        end
        if (mid_wr) tim_m = mid_tim;
        check($sformatf("R2 setup d=%0d", d), s, es);
        check($sformatf("R3 active d=%0d", d), p, ep);
        check($sformatf("R4 recovery d=%0d", d), r, er);
        check($sformatf("R5 wrong strobe d=%0d rd=%0d", d, rd), wrong, 0);
        check("R6 done during busy", done_early, 0);
        check("R6 done after busy", int'(done), 1);
        check("R5 strobes high after access", int'(rd_n && wr_n), 1);
        @(negedge clk);
        check("R6 done one clock", int'(done), 0);
        if (poke) check("R7 request while busy ignored", int'(busy), 0);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset rd_n", int'(rd_n), 1);
        check("R1 reset wr_n", int'(wr_n), 1);
        // R1: default timings for every drive, both directions
        for (int d = 0; d < 4; d++) begin
            for (int rd = 0; rd < 2; rd++) begin
                run_access(d, bit'(rd), 1'b0, '0, 1'b0);
                check("R1 default lengths", exp_setup(set_m, d) * 100 + exp_pulse(tim_m, d) * 10,
                      4 * 100 + 11 * 10);
            end
        end
        // R2/R3/R4/R9 sweep over register patterns
        for (int v = 0; v < 16; v++) begin
            logic [31:0] t;
            logic [7:0]  sb;
            for (int d = 0; d < 4; d++) begin
                t[31-8*d -: 4] = 4'((v + 5 * d) % 16);
                t[27-8*d -: 4] = 4'((15 - v + 3 * d) % 16);
            end
            sb = 8'(v * 37 + 11);
            cfg_write(1'b0, t);
            cfg_write(1'b1, {24'h0, sb});
            for (int d = 0; d < 4; d++)
                run_access(d, bit'((v + d) & 1), 1'b0, '0, (v % 4) == d);
        end
        // R8: write mid-access; this access keeps old timing, next uses new
        cfg_write(1'b0, 32'h2345_6789);
        run_access(1, 1'b1, 1'b1, 32'hF0E1_D2C3, 1'b0);
        run_access(1, 1'b1, 1'b0, '0, 1'b0);
        run_access(2, 1'b0, 1'b1, 32'h0000_0000, 1'b1);
        run_access(2, 1'b0, 1'b0, '0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule